// File: doc/BRIEF.md
# Token-Bounded Loop Pipeline Controller

This block sequences the control path of an inner loop so that several iterations can be active at the same time. It drives K datapath operations. Each operation uses a two-phase handshake: a sample phase that captures operands, then an update phase that commits the result. Every phase is a request/acknowledge pair. The controller launches iterations one at a time and counts per operation how many sample and update phases have finished. A request is released only when three things hold: the operation's own earlier phases are complete, the cross-operation dependency rules are met, and the token limit allows it.

Two K×K parameter bit matrices give the dependencies between operations. Bit `p*K+c` of the read-after-write map means that operation c samples a value that operation p writes. Operation c's sample in iteration i+1 then waits for p's update acknowledge of iteration i. Bit `r*K+w` of the write-after-read map means that operation w overwrites a value that operation r reads. Operation w's update in iteration i+1 then waits for r's sample acknowledge of iteration i.

A token pool of `CAP` entries limits the number of launched but unretired iterations. Iterations retire in launch order, once every operation has committed the oldest one. With `CAP = 1` the loop runs strictly one iteration at a time. A run begins with `start_i` and stops launching when the programmed count is reached or `cont_i` is low. It ends with a one-cycle `done_o` after the last retirement.

Top module: `loop_pipe_ctrl`

## Requirements
- R1: For every operation, the update request for iteration i is raised only after that operation's sample handshake of iteration i has completed.
- R2: A raised sample or update request stays high until its acknowledge is seen. An acknowledge in the same cycle as the request completes the handshake, and each handshake advances that operation to the next iteration.
- R3: If read-after-write bit p*K+c is set, operation c never raises its sample request for iteration i+1 before operation p has completed its update handshake of iteration i.
- R4: If write-after-read bit r*K+w is set, operation w never raises its update request for iteration i+1 before operation r has completed its sample handshake of iteration i.
- R5: At no time does the number of launched iterations minus the number fully committed exceed CAP (default 4). With slow commits and enough iterations, this difference reaches CAP.
- R6: With CAP = 1, no operation samples iteration i+1 before all operations have committed iteration i.
- R7: With cont_i held high, every operation completes exactly iter_cnt_i sample and update handshakes per run. A count of 0 produces no requests.
- R8: No iteration is launched while cont_i is low, and once cont_i goes low during a run, no further iteration is launched in that run. cont_i low from start gives zero iterations; a drop mid-run gives fewer than iter_cnt_i, with equal counts on every operation.
- R9: done_o is high for exactly one cycle per run, only after every launched iteration has been committed by all operations. No request is high from then until the next start.
- R10: After reset, done_o and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken when idle) |
| iter_cnt_i | input | CNT_W | Iterations to run, captured at start |
| cont_i | input | 1 | Loop-continue condition |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| samp_req_o | output | K | Per-operation sample request |
| samp_ack_i | input | K | Per-operation sample acknowledge |
| upd_req_o | output | K | Per-operation update request |
| upd_ack_i | input | K | Per-operation update acknowledge |

## Verification
Two instances are built side by side, one with four tokens and one with a single token. Both are swept over iteration counts 0, 1, 2, 3, 5 and 9 under three acknowledge patterns.

- **Immediate same-cycle acknowledges** exercise the fastest legal overlap.
- **Pseudo-random acknowledge delays** move the dependency waits into arbitrary orders, and the ordering rules are checked on every cycle.
- **Fast sampling with rare commits** lets the independent operation run ahead, so the run fills the token pool. This pattern separates a correct token limit from one that is off by one or missing, and the single-token instance must never exceed one iteration in flight.

Continue-condition runs, with the condition low from the start and with a drop mid-run, show that launching stops while the in-flight iterations still drain to completion.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
  typedef enum logic {
    LPC_IDLE = 1'b0,
    LPC_RUN  = 1'b1
  } lpc_state_e;
endpackage

// File: rtl/lpc_token_pool.sv
`timescale 1ns/1ps
module lpc_token_pool #(
  parameter int unsigned K     = 3,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned CAP   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      launch_en_i,
  input  logic [K-1:0][CNT_W-1:0]   upd_cnt_i,
  output logic [CNT_W-1:0]          launched_o,
  output logic                      idle_o
);
  localparam logic [CNT_W:0] CapV = (CNT_W+1)'(CAP);

  logic [CNT_W-1:0] launched_q, retired_q, occ;
  logic             launch, retire, oldest_done;

  assign occ    = launched_q - retired_q;
  assign launch = launch_en_i && ({1'b0, occ} < CapV);

  // oldest iteration retires once every operation committed it
  always_comb begin
    oldest_done = (retired_q != launched_q);
    for (int k = 0; k < K; k++)
      if (upd_cnt_i[k] <= retired_q) oldest_done = 1'b0;
  end
  assign retire = oldest_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launched_q <= '0;
      retired_q  <= '0;
    end else if (clear_i) begin
      launched_q <= '0;
      retired_q  <= '0;
    end else begin
      if (launch) launched_q <= launched_q + 1'b1;
      if (retire) retired_q  <= retired_q + 1'b1;
    end
  end

  assign launched_o = launched_q;
  assign idle_o     = (launched_q == retired_q);

  // R5
  token_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, launched_q - retired_q} <= CapV);

  // R9
  retire_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retired_q <= launched_q);
endmodule

// File: rtl/lpc_op_ctrl.sv
`timescale 1ns/1ps
module lpc_op_ctrl #(
  parameter int unsigned    K       = 3,
  parameter int unsigned    CNT_W   = 8,
  parameter int unsigned    IDX     = 0,
  parameter logic [K*K-1:0] RAW_MAP = '0,
  parameter logic [K*K-1:0] WAR_MAP = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic [CNT_W-1:0]          launched_i,
  input  logic [K-1:0][CNT_W-1:0]   samp_cnt_i,
  input  logic [K-1:0][CNT_W-1:0]   upd_cnt_i,
  input  logic                      samp_ack_i,
  input  logic                      upd_ack_i,
  output logic                      samp_req_o,
  output logic                      upd_req_o,
  output logic [CNT_W-1:0]          samp_cnt_o,
  output logic [CNT_W-1:0]          upd_cnt_o
);
  logic [CNT_W-1:0] samp_q, upd_q;
  logic             raw_ok, war_ok;

  // reader samples iteration s only after writer committed iterations 0..s-1
  always_comb begin
    raw_ok = 1'b1;
    for (int p = 0; p < K; p++)
      if (RAW_MAP[p*K+IDX] && (upd_cnt_i[p] < samp_q)) raw_ok = 1'b0;
  end

  // writer commits iteration u only after reader sampled iterations 0..u-1
  always_comb begin
    war_ok = 1'b1;
    for (int r = 0; r < K; r++)
      if (WAR_MAP[r*K+IDX] && (samp_cnt_i[r] < upd_q)) war_ok = 1'b0;
  end

  assign samp_req_o = (samp_q < launched_i) && raw_ok;
  assign upd_req_o  = (upd_q < samp_q) && war_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      upd_q  <= '0;
    end else if (clear_i) begin
      samp_q <= '0;
      upd_q  <= '0;
    end else begin
      if (samp_req_o && samp_ack_i) samp_q <= samp_q + 1'b1;
      if (upd_req_o && upd_ack_i)   upd_q  <= upd_q + 1'b1;
    end
  end

  assign samp_cnt_o = samp_q;
  assign upd_cnt_o  = upd_q;

  // R1
  commit_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q <= samp_q);

  // R2
  samp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_req_o && !samp_ack_i && !clear_i |=> samp_req_o);

  // R2
  upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_req_o && !upd_ack_i && !clear_i |=> upd_req_o);
endmodule

// File: rtl/loop_pipe_ctrl.sv
`timescale 1ns/1ps
module loop_pipe_ctrl
  import lpc_pkg::*;
#(
  parameter int unsigned    K       = 3,
  parameter int unsigned    CNT_W   = 8,
  parameter int unsigned    CAP     = 4,
  parameter logic [K*K-1:0] RAW_MAP = (K*K)'(2),
  parameter logic [K*K-1:0] WAR_MAP = (K*K)'(128)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] iter_cnt_i,
  input  logic             cont_i,
  output logic             done_o,
  output logic [K-1:0]     samp_req_o,
  input  logic [K-1:0]     samp_ack_i,
  output logic [K-1:0]     upd_req_o,
  input  logic [K-1:0]     upd_ack_i
);
  lpc_state_e               state_q;
  logic [CNT_W-1:0]         n_q, launched;
  logic                     stop_q, done_q, run, clear, launch_en, no_more, fin, idle;
  logic [K-1:0][CNT_W-1:0]  samp_cnt, upd_cnt;

  assign run       = (state_q == LPC_RUN);
  assign clear     = !run && start_i;
  assign launch_en = run && !stop_q && cont_i && (launched < n_q);
  assign no_more   = stop_q || !cont_i || (launched >= n_q);
  assign fin       = run && no_more && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LPC_IDLE;
      n_q     <= '0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (clear) begin
        state_q <= LPC_RUN;
        n_q     <= iter_cnt_i;
        stop_q  <= 1'b0;
      end else if (fin) begin
        state_q <= LPC_IDLE;
      end else if (run && !cont_i) begin
        stop_q  <= 1'b1;
      end
    end
  end

  assign done_o = done_q;

  lpc_token_pool #(.K(K), .CNT_W(CNT_W), .CAP(CAP)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .launch_en_i (launch_en),
    .upd_cnt_i   (upd_cnt),
    .launched_o  (launched),
    .idle_o      (idle)
  );

  for (genvar g = 0; g < K; g++) begin : g_op
    lpc_op_ctrl #(
      .K(K), .CNT_W(CNT_W), .IDX(g), .RAW_MAP(RAW_MAP), .WAR_MAP(WAR_MAP)
    ) u_op (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear),
      .launched_i (launched),
      .samp_cnt_i (samp_cnt),
      .upd_cnt_i  (upd_cnt),
      .samp_ack_i (samp_ack_i[g]),
      .upd_ack_i  (upd_ack_i[g]),
      .samp_req_o (samp_req_o[g]),
      .upd_req_o  (upd_req_o[g]),
      .samp_cnt_o (samp_cnt[g]),
      .upd_cnt_o  (upd_cnt[g])
    );
  end

  for (genvar gp = 0; gp < K; gp++) begin : g_dep_p
    for (genvar gc = 0; gc < K; gc++) begin : g_dep_c
      if (RAW_MAP[gp*K+gc]) begin : g_raw
        // R3
        raw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          {1'b0, samp_cnt[gc]} <= {1'b0, upd_cnt[gp]} + (CNT_W+1)'(1));
      end
      if (WAR_MAP[gp*K+gc]) begin : g_war
        // R4
        war_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          {1'b0, upd_cnt[gc]} <= {1'b0, samp_cnt[gp]} + (CNT_W+1)'(1));
      end
    end
  end

  // R7
  launch_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> launched <= n_q);

  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && (stop_q || !cont_i) && !start_i |=> $stable(launched));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (samp_req_o == '0) && (upd_req_o == '0));
endmodule

// File: tb/lpc_agent.sv
`timescale 1ns/1ps
module lpc_agent #(
  parameter int unsigned    K    = 3,
  parameter int unsigned    CAP  = 4,
  parameter logic [K*K-1:0] RAW  = '0,
  parameter logic [K*K-1:0] WAR  = '0,
  parameter logic [15:0]    SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         done_i,
  input  logic [1:0]   mode_i,
  input  logic [K-1:0] samp_req_i,
  input  logic [K-1:0] upd_req_i,
  output logic [K-1:0] samp_ack_o,
  output logic [K-1:0] upd_ack_o
);
  int sc [K];
  int uc [K];
  int n_chk = 0, n_fail = 0, peak = 0, done_cnt = 0;
  logic [K-1:0] pend_s = '0, pend_u = '0;
  logic done_prev = 1'b0;
  logic [15:0] lfsr = SEED;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cap=%0d t=%0t act=%0d exp=%0d", tag, CAP, $time, act, exp);
    end
  endtask

  initial begin
    for (int k = 0; k < K; k++) begin sc[k] = 0; uc[k] = 0; end
    samp_ack_o = '0;
    upd_ack_o  = '0;
    forever begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int k = 0; k < K; k++) begin
        logic gs, gu;
        gs = (mode_i != 2'd1) || lfsr[k];
        if (mode_i == 2'd0)      gu = 1'b1;
        else if (mode_i == 2'd1) gu = lfsr[k+4];
        else                     gu = (k == 0) || (lfsr[3:0] == 4'd0);
        samp_ack_o[k] = samp_req_i[k] && gs;
        upd_ack_o[k]  = upd_req_i[k] && gu;
      end
      #1;
      if (rst_ni) begin
        if (start_i) begin
          for (int k = 0; k < K; k++) begin sc[k] = 0; uc[k] = 0; end
          done_cnt = 0;
        end
        for (int k = 0; k < K; k++) begin
          if (pend_s[k]) chk(samp_req_i[k], "R2 sample request dropped", 0, 1);
          if (pend_u[k]) chk(upd_req_i[k], "R2 update request dropped", 0, 1);
          if (samp_req_i[k])
            for (int p = 0; p < K; p++)
              if (RAW[p*K+k]) chk(uc[p] >= sc[k], "R3 read-after-write", uc[p], sc[k]);
          if (upd_req_i[k]) begin
            chk(uc[k] < sc[k], "R1 update before sample", uc[k], sc[k]);
            for (int r = 0; r < K; r++)
              if (WAR[r*K+k]) chk(sc[r] >= uc[k], "R4 write-after-read", sc[r], uc[k]);
          end
        end
        if (done_i) begin
          chk(!done_prev, "R9 done longer than one cycle", 1, 0);
          if (!done_prev) done_cnt++;
          chk((samp_req_i == '0) && (upd_req_i == '0), "R9 request at done",
              int'(samp_req_i | upd_req_i), 0);
          for (int k = 0; k < K; k++)
            chk((sc[k] == uc[k]) && (sc[k] == sc[0]), "R9 uncommitted at done", uc[k], sc[0]);
        end
        done_prev = done_i;
        for (int k = 0; k < K; k++) begin
          pend_s[k] = samp_req_i[k] && !samp_ack_o[k];
          pend_u[k] = upd_req_i[k] && !upd_ack_o[k];
          if (samp_req_i[k] && samp_ack_o[k]) sc[k]++;
          if (upd_req_i[k] && upd_ack_o[k])   uc[k]++;
        end
        begin
          int mx, mn;
          mx = sc[0]; mn = uc[0];
          for (int k = 1; k < K; k++) begin
            if (sc[k] > mx) mx = sc[k];
            if (uc[k] < mn) mn = uc[k];
          end
          if (mx - mn > peak) peak = mx - mn;
          if (mx != mn)
            chk(mx - mn <= int'(CAP), (CAP == 1) ? "R6 overlap" : "R5 token cap", mx - mn, CAP);
        end
      end
    end
  end
endmodule

// File: tb/loop_pipe_ctrl_test.sv
`timescale 1ns/1ps
module loop_pipe_ctrl_test;
  localparam int unsigned    K     = 3;
  localparam int unsigned    CNT_W = 8;
  localparam logic [K*K-1:0] RAW   = 9'b000_000_010;  // op0 -> op1
  localparam logic [K*K-1:0] WAR   = 9'b010_000_000;  // reader op2, writer op1

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cont = 1'b1;
  logic [CNT_W-1:0] cnt = '0;
  logic [1:0] mode = 2'd0;
  logic done_a, done_b;
  logic [K-1:0] sreq_a, sack_a, ureq_a, uack_a;
  logic [K-1:0] sreq_b, sack_b, ureq_b, uack_b;
  int n_chk = 0, n_fail = 0;

  loop_pipe_ctrl #(.K(K), .CNT_W(CNT_W), .CAP(4), .RAW_MAP(RAW), .WAR_MAP(WAR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .iter_cnt_i(cnt), .cont_i(cont),
    .done_o(done_a), .samp_req_o(sreq_a), .samp_ack_i(sack_a),
    .upd_req_o(ureq_a), .upd_ack_i(uack_a));

  loop_pipe_ctrl #(.K(K), .CNT_W(CNT_W), .CAP(1), .RAW_MAP(RAW), .WAR_MAP(WAR)) uut_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .iter_cnt_i(cnt), .cont_i(cont),
    .done_o(done_b), .samp_req_o(sreq_b), .samp_ack_i(sack_b),
    .upd_req_o(ureq_b), .upd_ack_i(uack_b));

  lpc_agent #(.K(K), .CAP(4), .RAW(RAW), .WAR(WAR), .SEED(16'hACE1)) ag (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done_a), .mode_i(mode),
    .samp_req_i(sreq_a), .upd_req_i(ureq_a), .samp_ack_o(sack_a), .upd_ack_o(uack_a));

  lpc_agent #(.K(K), .CAP(1), .RAW(RAW), .WAR(WAR), .SEED(16'h5EED)) ag_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done_b), .mode_i(mode),
    .samp_req_i(sreq_b), .upd_req_i(ureq_b), .samp_ack_o(sack_b), .upd_ack_o(uack_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + ag.n_chk + ag_seq.n_chk, n_fail + ag.n_fail + ag_seq.n_fail);
  endtask

  // drop_at: -1 keep cont high, 0 low from start, >0 drop after that many cycles
  task automatic run(input int n, input int md, input int drop_at);
    @(negedge clk);
    mode  = 2'(md);
    cnt   = CNT_W'(n);
    cont  = (drop_at != 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (drop_at > 0 && c == drop_at) cont = 1'b0;
      if (ag.done_cnt > 0 && ag_seq.done_cnt > 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    #2;
    chk(ag.done_cnt == 1, "R9 done count cap4", ag.done_cnt, 1);
    chk(ag_seq.done_cnt == 1, "R9 done count cap1", ag_seq.done_cnt, 1);
    chk((sreq_a | ureq_a | sreq_b | ureq_b) == '0, "R9 request after done",
        int'(sreq_a | ureq_a | sreq_b | ureq_b), 0);
    for (int k = 0; k < K; k++) begin
      if (drop_at < 0) begin
        chk(ag.sc[k] == n && ag.uc[k] == n, "R7 iterations cap4", ag.uc[k], n);
        chk(ag_seq.sc[k] == n && ag_seq.uc[k] == n, "R7 iterations cap1", ag_seq.uc[k], n);
      end else if (drop_at == 0) begin
        chk(ag.sc[k] == 0 && ag_seq.sc[k] == 0, "R8 launch with cont low",
            ag.sc[k] + ag_seq.sc[k], 0);
      end else begin
        chk(ag.sc[k] == ag.sc[0] && ag.uc[k] == ag.sc[0], "R8 unequal cap4", ag.uc[k], ag.sc[0]);
        chk(ag_seq.sc[k] == ag_seq.sc[0] && ag_seq.uc[k] == ag_seq.sc[0], "R8 unequal cap1",
            ag_seq.uc[k], ag_seq.sc[0]);
      end
    end
    if (drop_at > 0) begin
      chk(ag.sc[0] > 0 && ag.sc[0] < n, "R8 mid drop cap4", ag.sc[0], n);
      chk(ag_seq.sc[0] > 0 && ag_seq.sc[0] < n, "R8 mid drop cap1", ag_seq.sc[0], n);
    end
    cont = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(done_a == 1'b0 && done_b == 1'b0, "R10 done in reset", int'(done_a | done_b), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk((sreq_a | ureq_a | sreq_b | ureq_b) == '0, "R10 request after reset",
        int'(sreq_a | ureq_a | sreq_b | ureq_b), 0);
    chk(done_a == 1'b0 && done_b == 1'b0, "R10 done after reset", int'(done_a | done_b), 0);

    for (int md = 0; md < 3; md++) begin
      run(0, md, -1);
      run(1, md, -1);
      run(2, md, -1);
      run(3, md, -1);
      run(5, md, -1);
      run(9, md, -1);
    end
    run(12, 0, 0);
    run(12, 2, 0);
    run(40, 0, 6);
    run(40, 1, 6);
    run(40, 2, 6);

    chk(ag.peak == 4, "R5 peak in flight cap4", ag.peak, 4);
    chk(ag_seq.peak == 1, "R6 peak in flight cap1", ag_seq.peak, 1);
    summary();
    $finish;
  end
endmodule